// File: doc/BRIEF.md
# Synchronous DRAM Burst Controller

This block sits between a host and a single-bank synchronous DRAM and turns host burst requests into device commands. Each request carries a start address (row and column) and a direction. The controller opens the row, waits a fixed number of cycles, issues one column command with only the starting column, and then streams a fixed-length burst of words. Write words are pulled from the host one per cycle. Read words are returned with a per-word valid strobe. Every burst closes its row with a precharge.

After reset, the controller holds the device idle for a programmable time. It then precharges, performs one refresh and loads the mode register with the burst length and CAS latency. Only after that does it accept requests. An interval timer raises refresh requests during normal operation. A pending refresh is served only while the controller is idle, and before any new request is taken. A row counter supplies the address of each refresh and steps through the rows in order.

Top module: `sdram_burst_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `sd_cmd` is NOP, and `req_ready`, `rd_valid`, `wr_take` and `sd_dq_oe` are all 0.
- R2: `sd_cmd` uses this code: 0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode load. After reset the controller issues only NOP for at least INIT_WAIT cycles. It then issues exactly precharge, refresh and mode load, in that order, and raises `req_ready` only after the mode load.
- R3: During the mode load, `sd_addr` bits [2:0] hold log2(BL), bits [6:4] hold CL, and every other bit is 0.
- R4: A request is accepted on the rising edge where `req_valid` and `req_ready` are both 1. `req_addr` is split as {row, column}, with the column in the low COL_W bits. The activate carries the row on `sd_addr`, and the single column command carries the column.
- R5: The column command appears exactly TRCD cycles after the activate of its burst.
- R6: A read burst returns BL words on `rd_data`, one per cycle in consecutive cycles with `rd_valid` high, in column order. The first word appears TRCD+CL+1 cycles after the accepting edge. The device drives word k CL+k cycles after it samples the read command.
- R7: A write burst pulses `wr_take` once per word, BL times. Each pulse follows the edge at which the word then on `wr_data` was taken. The words are driven on `sd_dq_out` with `sd_dq_oe` high in the write-command cycle and the BL-1 cycles after it, and land at consecutive columns.
- R8: Every burst ends with a precharge. No activate and no refresh is issued while a row is open.
- R9: When the controller is idle, refresh commands follow one another exactly REF_INTERVAL cycles apart.
- R10: The refresh row address starts at 0 after reset and rises by one with each refresh, including the one in the init sequence.
- R11: `req_ready` is 0 from the accepting edge until the burst's precharge has completed, so at most one row is open at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything happens on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a burst request |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ROW_W+COL_W | {row, start column} |
| wr_data | input | DW | Next write word offered by the host |
| wr_take | output | 1 | The offered write word was taken; present the next one |
| rd_data | output | DW | Returned read word |
| rd_valid | output | 1 | `rd_data` holds a burst word |
| sd_cmd | output | 3 | Device command (code in R2) |
| sd_addr | output | ROW_W | Row, column, refresh row or mode word (ROW_W >= COL_W, ROW_W >= 7) |
| sd_dq_out | output | DW | Write data toward the device |
| sd_dq_oe | output | 1 | Controller drives the data lines |
| sd_dq_in | input | DW | Read data from the device |

## Verification
Bursts are run with several data patterns, at different rows and column offsets. Writes and reads alternate back to back, so each read can only match if the column stepping and word order were right in both directions. The read latency is measured from the accepting edge, which separates a wrong activate delay from a wrong CAS sampling point. Long idle stretches, and streams of bursts that run into refresh ticks, show whether refreshes keep their spacing and row order and stay out of open rows.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } sd_cmd_e;
endpackage

// File: rtl/sdram_cycle_cnt.sv
module sdram_cycle_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else            count <= count + 1'b1;
  end
endmodule

// File: rtl/sdram_refresh_gen.sv
module sdram_refresh_gen #(
  parameter int INTERVAL = 780,
  parameter int ROW_W    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_done,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);
  localparam int IW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [IW-1:0] LAST = IW'(INTERVAL - 1);

  logic [IW-1:0] icnt;
  logic          tick;

  assign tick = (icnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      icnt     <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      icnt     <= tick ? '0 : icnt + 1'b1;
      ref_pend <= tick | (ref_pend & ~ref_done);
      if (ref_done) ref_row <= ref_row + 1'b1;
    end
  end
endmodule

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int DW           = 16,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int BL           = 4,
  parameter int CL           = 1,
  parameter int TRCD         = 2,
  parameter int TRP          = 2,
  parameter int TRFC         = 4,
  parameter int TMRD         = 2,
  parameter int INIT_WAIT    = 20,
  parameter int REF_INTERVAL = 780
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DW-1:0]          wr_data,
  output logic                   wr_take,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_valid,
  output logic [2:0]             sd_cmd,
  output logic [ROW_W-1:0]       sd_addr,
  output logic [DW-1:0]          sd_dq_out,
  output logic                   sd_dq_oe,
  input  logic [DW-1:0]          sd_dq_in
);
  localparam int CNT_W = $clog2(INIT_WAIT + CL + BL + TRFC + TRCD + TRP + TMRD + 2);
  localparam int BL_CODE = $clog2(BL);
  localparam logic [CNT_W-1:0] C_INIT   = CNT_W'(INIT_WAIT - 1);
  localparam logic [CNT_W-1:0] C_TRCD   = CNT_W'(TRCD - 1);
  localparam logic [CNT_W-1:0] C_TRP    = CNT_W'(TRP - 1);
  localparam logic [CNT_W-1:0] C_TRFC   = CNT_W'(TRFC - 1);
  localparam logic [CNT_W-1:0] C_TMRD   = CNT_W'(TMRD - 1);
  localparam logic [CNT_W-1:0] C_CL     = CNT_W'(CL);
  localparam logic [CNT_W-1:0] C_RD_END = CNT_W'(CL + BL - 1);
  localparam logic [CNT_W-1:0] C_WR_END = CNT_W'(BL - 1);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'((CL << 4) | BL_CODE);

  typedef enum logic [2:0] {
    ST_INIT, ST_INIT_REF, ST_INIT_MRS, ST_IDLE, ST_ACT, ST_RD, ST_WR, ST_WAIT
  } st_e;

  st_e              st, st_nxt, ret_st;
  logic [CNT_W-1:0] cnt, lim;
  logic             cnt_clr;
  logic             ref_pend, ref_done;
  logic [ROW_W-1:0] ref_row;
  logic [COL_W-1:0] col_q;
  logic             wr_op;

  sdram_cycle_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .count(cnt)
  );

  sdram_refresh_gen #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_ref (
    .clk(clk), .rst(rst), .ref_done(ref_done), .ref_pend(ref_pend), .ref_row(ref_row)
  );

  assign req_ready = (st == ST_IDLE) && !ref_pend;
  assign ref_done  = (st == ST_INIT_REF) || ((st == ST_IDLE) && ref_pend);
  assign cnt_clr   = (st_nxt != st);

  always_comb begin
    st_nxt = st;
    case (st)
      ST_INIT:     if (cnt == C_INIT) st_nxt = ST_WAIT;
      ST_INIT_REF: st_nxt = ST_WAIT;
      ST_INIT_MRS: st_nxt = ST_WAIT;
      ST_IDLE: begin
        if (ref_pend)       st_nxt = ST_WAIT;
        else if (req_valid) st_nxt = ST_ACT;
      end
      ST_ACT:  if (cnt == C_TRCD) st_nxt = wr_op ? ST_WR : ST_RD;
      ST_RD:   if (cnt == C_RD_END) st_nxt = ST_WAIT;
      ST_WR:   if (cnt == C_WR_END) st_nxt = ST_WAIT;
      ST_WAIT: if (cnt == lim) st_nxt = ret_st;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_INIT;
      ret_st    <= ST_IDLE;
      lim       <= '0;
      sd_cmd    <= CMD_NOP;
      sd_addr   <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      wr_take   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      col_q     <= '0;
      wr_op     <= 1'b0;
    end else begin
      st       <= st_nxt;
      sd_cmd   <= CMD_NOP;
      wr_take  <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        ST_INIT: if (cnt == C_INIT) begin
          sd_cmd  <= CMD_PRE;
          sd_addr <= '0;
          ret_st  <= ST_INIT_REF;
          lim     <= C_TRP;
        end
        ST_INIT_REF: begin
          sd_cmd  <= CMD_REF;
          sd_addr <= ref_row;
          ret_st  <= ST_INIT_MRS;
          lim     <= C_TRFC;
        end
        ST_INIT_MRS: begin
          sd_cmd  <= CMD_MRS;
          sd_addr <= MODE_WORD;
          ret_st  <= ST_IDLE;
          lim     <= C_TMRD;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            sd_cmd  <= CMD_REF;
            sd_addr <= ref_row;
            ret_st  <= ST_IDLE;
            lim     <= C_TRFC;
          end else if (req_valid) begin
            sd_cmd  <= CMD_ACT;
            sd_addr <= req_addr[ROW_W+COL_W-1:COL_W];
            col_q   <= req_addr[COL_W-1:0];
            wr_op   <= req_write;
          end
        end
        ST_ACT: if (cnt == C_TRCD) begin
          sd_cmd  <= wr_op ? CMD_WR : CMD_RD;
          sd_addr <= ROW_W'(col_q);
          if (wr_op) begin
            sd_dq_out <= wr_data;
            sd_dq_oe  <= 1'b1;
            wr_take   <= 1'b1;
          end
        end
        ST_RD: begin
          if (cnt >= C_CL) begin
            rd_valid <= 1'b1;
            rd_data  <= sd_dq_in;
          end
          if (cnt == C_RD_END) begin
            sd_cmd <= CMD_PRE;
            ret_st <= ST_IDLE;
            lim    <= C_TRP;
          end
        end
        ST_WR: begin
          if (cnt == C_WR_END) begin
            sd_dq_oe <= 1'b0;
            sd_cmd   <= CMD_PRE;
            ret_st   <= ST_IDLE;
            lim      <= C_TRP;
          end else begin
            sd_dq_out <= wr_data;
            wr_take   <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_burst_ctrl_chk.sv
module sdram_burst_ctrl_chk
  import sdram_ctrl_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int TRCD  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             rd_valid,
  input logic [2:0]       sd_cmd,
  input logic [ROW_W-1:0] sd_addr,
  input logic             sd_dq_oe
);
  localparam logic [7:0] K_TRCD = 8'(TRCD);

  logic             row_open, mode_seen, ref_seen;
  logic [7:0]       since_act;
  logic [ROW_W-1:0] last_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_open  <= 1'b0;
      mode_seen <= 1'b0;
      ref_seen  <= 1'b0;
      since_act <= 8'hFF;
      last_ref  <= '0;
    end else begin
      if (sd_cmd == CMD_ACT) row_open <= 1'b1;
      else if (sd_cmd == CMD_PRE) row_open <= 1'b0;
      if (sd_cmd == CMD_MRS) mode_seen <= 1'b1;
      if (sd_cmd == CMD_REF) begin
        ref_seen <= 1'b1;
        last_ref <= sd_addr;
      end
      if (sd_cmd == CMD_ACT) since_act <= 8'd1;
      else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
    end
  end

  // R2
  ready_after_mode_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mode_seen);

  // R5
  act_to_col_chk: assert property (@(posedge clk) disable iff (rst)
    (sd_cmd == CMD_RD || sd_cmd == CMD_WR) |-> since_act == K_TRCD);

  // R8
  no_ref_open_chk: assert property (@(posedge clk) disable iff (rst)
    (sd_cmd == CMD_REF) |-> !row_open);

  // R8
  no_double_act_chk: assert property (@(posedge clk) disable iff (rst)
    (sd_cmd == CMD_ACT) |-> !row_open);

  // R11
  ready_closed_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !row_open);

  // R6
  rd_not_driving_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !sd_dq_oe);

  // R10
  ref_row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sd_cmd == CMD_REF && ref_seen) |-> sd_addr == last_ref + 1'b1);
endmodule

bind sdram_burst_ctrl sdram_burst_ctrl_chk #(.ROW_W(ROW_W), .TRCD(TRCD)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
  .sd_cmd(sd_cmd), .sd_addr(sd_addr), .sd_dq_oe(sd_dq_oe)
);

// File: tb/test_sdram_burst_ctrl.sv
module test_sdram_burst_ctrl;
  import sdram_ctrl_pkg::*;

  localparam int CLK_PERIOD   = 10;
  localparam int DW           = 16;
  localparam int ROW_W        = 12;
  localparam int COL_W        = 9;
  localparam int BL           = 4;
  localparam int CL           = 1;
  localparam int TRCD         = 2;
  localparam int TRP          = 2;
  localparam int TRFC         = 4;
  localparam int TMRD         = 2;
  localparam int INIT_WAIT    = 20;
  localparam int REF_INTERVAL = 150;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   req_valid = 1'b0;
  logic                   req_ready;
  logic                   req_write = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DW-1:0]          wr_data = '0;
  logic                   wr_take;
  logic [DW-1:0]          rd_data;
  logic                   rd_valid;
  logic [2:0]             sd_cmd;
  logic [ROW_W-1:0]       sd_addr;
  logic [DW-1:0]          sd_dq_out;
  logic                   sd_dq_oe;
  logic [DW-1:0]          sd_dq_in = '0;

  sdram_burst_ctrl #(
    .DW(DW), .ROW_W(ROW_W), .COL_W(COL_W), .BL(BL), .CL(CL), .TRCD(TRCD),
    .TRP(TRP), .TRFC(TRFC), .TMRD(TMRD), .INIT_WAIT(INIT_WAIT),
    .REF_INTERVAL(REF_INTERVAL)
  ) i_sdram_burst_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .wr_data(wr_data),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .sd_cmd(sd_cmd), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // device model state
  logic [DW-1:0] mem [int];
  int cyc = 0;
  bit open = 0;
  int open_row = 0, act_cyc = 0;
  int proto_err = 0, trcd_err = 0;
  int n_log = 0, first_cyc = 0;
  logic [2:0] cmd_log [0:7];
  int n_ref = 0;
  int ref_row_log [0:63];
  int ref_cyc_log [0:63];
  logic [ROW_W-1:0] mode_val = '0;
  bit wr_act = 0, rd_act = 0;
  int wr_k = 0, rd_k = 0, wr_base = 0, rd_base = 0;

  function automatic int mkey(int row, int col);
    return row * (1 << COL_W) + col;
  endfunction

  function automatic logic [DW-1:0] pat(int seed, int b);
    return DW'(seed * 16'h0101 + b * 16'h1111) ^ DW'(16'h5A00 >> b);
  endfunction

  always @(posedge clk) begin
    logic [DW-1:0] drv;
    cyc = cyc + 1;
    drv = DW'(16'hDEAD);
    if (!rst) begin
      if (sd_cmd != CMD_NOP && n_log < 8) begin
        if (n_log == 0) first_cyc = cyc;
        cmd_log[n_log] = sd_cmd;
        n_log = n_log + 1;
      end
      case (sd_cmd)
        CMD_ACT: begin
          if (open) proto_err = proto_err + 1;
          open = 1; open_row = int'(sd_addr); act_cyc = cyc;
        end
        CMD_RD, CMD_WR: begin
          if (!open) proto_err = proto_err + 1;
          if (cyc - act_cyc != TRCD) trcd_err = trcd_err + 1;
          if (sd_cmd == CMD_WR) begin
            wr_act = 1; wr_k = 0; wr_base = mkey(open_row, int'(sd_addr[COL_W-1:0]));
          end else begin
            rd_act = 1; rd_k = 0; rd_base = mkey(open_row, int'(sd_addr[COL_W-1:0]));
          end
        end
        CMD_PRE: open = 0;
        CMD_REF: begin
          if (open) proto_err = proto_err + 1;
          if (n_ref < 64) begin
            ref_row_log[n_ref] = int'(sd_addr);
            ref_cyc_log[n_ref] = cyc;
          end
          n_ref = n_ref + 1;
        end
        CMD_MRS: mode_val = sd_addr;
        default: ;
      endcase
      if (wr_act) begin
        if (!sd_dq_oe) proto_err = proto_err + 1;
        mem[wr_base + wr_k] = sd_dq_out;
        wr_k = wr_k + 1;
        if (wr_k == BL) wr_act = 0;
      end
      if (rd_act) begin
        if (rd_k >= CL - 1) begin
          int a;
          a = rd_base + rd_k - (CL - 1);
          drv = mem.exists(a) ? mem[a] : DW'(16'hBAD0);
        end
        rd_k = rd_k + 1;
        if (rd_k == CL - 1 + BL) rd_act = 0;
      end
    end
    sd_dq_in <= drv;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 cmd in reset", 32'(sd_cmd), 32'(CMD_NOP));
    chk("R1 ready in reset", 32'(req_ready), 0);
    chk("R1 strobes in reset", {29'd0, rd_valid, wr_take, sd_dq_oe}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cmd after reset", 32'(sd_cmd), 32'(CMD_NOP));
    chk("R1 ready after reset", 32'(req_ready), 0);
  endtask

  task automatic t_init(input int rel);
    wait_ready();
    chk("R2 init cmd count", 32'(n_log), 3);
    chk("R2 init first", 32'(cmd_log[0]), 32'(CMD_PRE));
    chk("R2 init second", 32'(cmd_log[1]), 32'(CMD_REF));
    chk("R2 init third", 32'(cmd_log[2]), 32'(CMD_MRS));
    chk("R2 init wait", 32'(first_cyc - rel >= INIT_WAIT), 1);
    chk("R3 mode word", 32'(mode_val), 32'((CL << 4) | $clog2(BL)));
    chk("R10 init refresh row", 32'(ref_row_log[0]), 0);
  endtask

  task automatic t_write(input int row, input int col, input int seed);
    int takes;
    @(negedge clk);
    req_addr = {ROW_W'(row), COL_W'(col)};
    req_write = 1'b1; req_valid = 1'b1; wr_data = pat(seed, 0);
    wait_ready();
    @(posedge clk);
    takes = 0;
    for (int m = 0; m < 30; m++) begin
      @(negedge clk);
      if (m == 0) req_valid = 1'b0;
      if (wr_take) begin
        takes = takes + 1;
        if (takes < BL) wr_data = pat(seed, takes);
      end
    end
    chk("R7 write word count", 32'(takes), BL);
    for (int b = 0; b < BL; b++)
      chk("R7 stored word", 32'(mem.exists(mkey(row, col + b)) ? mem[mkey(row, col + b)] : 'hFFFF),
          32'(pat(seed, b)));
  endtask

  task automatic t_read(input int row, input int col, input int seed);
    int got, lat, last;
    logic [DW-1:0] w [0:15];
    @(negedge clk);
    req_addr = {ROW_W'(row), COL_W'(col)};
    req_write = 1'b0; req_valid = 1'b1;
    wait_ready();
    @(posedge clk);
    got = 0; lat = -1; last = -1;
    for (int m = 0; m < 30; m++) begin
      @(negedge clk);
      if (m == 0) req_valid = 1'b0;
      if (rd_valid) begin
        if (lat < 0) lat = m;
        last = m;
        if (got < 16) w[got] = rd_data;
        got = got + 1;
      end
    end
    chk("R6 read word count", 32'(got), BL);
    chk("R6 read latency", 32'(lat), TRCD + CL + 1);
    chk("R6 consecutive words", 32'(last - lat), BL - 1);
    for (int b = 0; b < BL && b < got; b++)
      chk("R6 read word", 32'(w[b]), 32'(pat(seed, b)));
    chk("R4 activate row", 32'(open_row), 32'(row));
  endtask

  task automatic t_refresh();
    int n0, t;
    n0 = n_ref; t = 0;
    while (n_ref < n0 + 3 && t < 2000) begin @(negedge clk); t = t + 1; end
    chk("R9 refresh gap", 32'(ref_cyc_log[n0 + 2] - ref_cyc_log[n0 + 1]), REF_INTERVAL);
    for (int i = 1; i < n_ref && i < 64; i++)
      chk("R10 refresh row order", 32'(ref_row_log[i]), 32'(i));
  endtask

  task automatic t_stress();
    int n0;
    n0 = n_ref;
    for (int i = 0; i < 10; i++) begin
      t_write((i * 37 + 5) % 4096, (i * 8 + 3) % 500, 40 + i);
      t_read((i * 37 + 5) % 4096, (i * 8 + 3) % 500, 40 + i);
    end
    chk("R8 refreshes during bursts", 32'(n_ref > n0), 1);
    chk("R8 protocol errors", 32'(proto_err), 0);
    chk("R5 activate-to-column errors", 32'(trcd_err), 0);
  endtask

  initial begin
    int rel;
    t_reset();
    rel = cyc;
    t_init(rel);
    t_write(3, 16, 1);
    t_read(3, 16, 1);
    t_write(4095, 500, 2);
    t_write(3, 20, 3);
    t_read(4095, 500, 2);
    t_read(3, 20, 3);
    t_write(3, 16, 4);
    t_read(3, 16, 4);
    t_refresh();
    t_stress();
    t_refresh();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule